// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a set of device interrupt lines and a message-based interrupt fabric. A separate register block holds one 64-bit redirection entry per pin and presents the whole table on `rte_i`. The engine turns line activity into per-pin pending requests. It applies each entry's mask and trigger mode, then picks the lowest-numbered deliverable pin. It emits that pin's request as a 32-bit address / 32-bit data message on a valid/ready port.

Level-triggered pins follow a remote-request handshake. A delivered level pin sets its remote-IRR bit, and while that bit is set the pin sends nothing more. An end-of-interrupt carrying the matching vector clears the bit. If the line is still high at that point, the pin is delivered again. The engine holds the remote-IRR bits itself and shows them on `rirr_o`, so the register block can return them on reads. End-of-interrupt notices go through a small queue. They take effect only when no message is held at the output.

Top module: `irqd_engine`

## Requirements
- R1: After reset `msg_valid_o` is low, no request is pending and `rirr_o` is all zero.
- R2: For a level-triggered entry (bit 15 = 1), the pin's request is high while its line is high and low while its line is low. A level pin with remote-IRR clear sends exactly one message, and its handshake sets that pin's `rirr_o` bit. While the bit is set, the pin sends no further message.
- R3: An edge-triggered entry (bit 15 = 0) records a request on a rising edge of its line only if the entry is unmasked (bit 16 = 0). A rising edge on a masked edge pin is discarded, so unmasking it later sends nothing. The handshake of an edge message clears that pin's request.
- R4: Line 0 drives pin 2, and line k drives pin k for 0 < k < NUM_PINS. Lines at index NUM_PINS or above have no effect. Pin 0 receives no requests.
- R5: A pending level request on a masked entry is kept. Once the entry is unmasked, the request is delivered with no further line activity.
- R6: When several pins are deliverable, messages leave in ascending pin order.
- R7: Entry fields are: vector 7:0, delivery mode 10:8, destination mode 11, trigger 15, mask 16, destination 63:48. The message address is 0xFEE00000 | destination<<4 | destination-mode<<2. The message data is vector | delivery-mode<<8 | trigger<<15.
- R8: While `msg_valid_o` is high and `msg_ready_i` is low, the message stays valid with unchanged address and data, and the request stays pending.
- R9: An end-of-interrupt with vector V clears remote-IRR on every entry whose remote-IRR is set and whose vector equals V. An entry with a different vector is unaffected. A cleared entry that is unmasked and still has its line high is delivered again.
- R10: An end-of-interrupt that arrives while a message is held takes effect only after that message's handshake. Queued notices are applied in arrival order.
- R11: An entry set to edge-triggered has its remote-IRR bit cleared within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | NUM_LINES | Device interrupt line levels |
| rte_i | input | NUM_PINS*64 | Redirection table, entry p at bits p*64+63:p*64 |
| eoi_valid_i | input | 1 | End-of-interrupt notice strobe |
| eoi_vec_i | input | 8 | Vector carried by the notice |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Fabric accepts the message |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |
| rirr_o | output | NUM_PINS | Remote-IRR bit per pin |

## Verification
The bench targets the masked edge that a careless design would hold pending and send after unmask, and the masked level request that one might drop instead of delivering on unmask. It sends end-of-interrupts with wrong and right vectors to a level pin whose line stays high. A design that cleared remote-IRR regardless of vector, or failed to re-deliver, would show a wrong message count. An end-of-interrupt is issued while the output is stalled, to catch a design that applies it early and reorders the re-delivery ahead of the held message. Line 0, lines beyond the pin count and a level-to-edge rewrite check the routing and the remote-IRR clear. Random entries check every message field.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ENT_W     = 64;
  localparam int VEC_LSB   = 0;
  localparam int DLV_LSB   = 8;
  localparam int DSTM_BIT  = 11;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 48;
  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        trig;   // 1 = level
    logic        dstm;
    logic [2:0]  dlv;
    logic [7:0]  vec;
  } ent_t;

  function automatic ent_t ent_unpack(input logic [ENT_W-1:0] e);
    ent_t r;
    r.vec  = e[VEC_LSB +: 8];
    r.dlv  = e[DLV_LSB +: 3];
    r.dstm = e[DSTM_BIT];
    r.trig = e[TRIG_BIT];
    r.mask = e[MASK_BIT];
    r.dest = e[DEST_LSB +: 16];
    return r;
  endfunction

  function automatic logic [31:0] msg_addr(input ent_t e);
    return MSG_BASE | {12'd0, e.dest, 4'd0} | {29'd0, e.dstm, 2'd0};
  endfunction

  function automatic logic [31:0] msg_data(input ent_t e);
    return {16'd0, e.trig, 4'd0, e.dlv, e.vec};
  endfunction
endpackage

// File: rtl/irqd_pin_front.sv
module irqd_pin_front #(
  parameter int NUM_PINS  = 24,
  parameter int NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_PINS-1:0]  pin_lvl_o,
  output logic [NUM_PINS-1:0]  pin_rise_o
);
  logic [NUM_PINS-1:0] lvl_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    if (p == 0) begin : g_zero
      assign pin_lvl_o[p] = 1'b0;
    end else if (p == 2) begin : g_two
      if (p < NUM_LINES) begin : g_both
        assign pin_lvl_o[p] = lines_i[0] | lines_i[p];
      end else begin : g_only0
        assign pin_lvl_o[p] = lines_i[0];
      end
    end else if (p < NUM_LINES) begin : g_direct
      assign pin_lvl_o[p] = lines_i[p];
    end else begin : g_none
      assign pin_lvl_o[p] = 1'b0;
    end
  end

  if (NUM_LINES > NUM_PINS) begin : g_extra
    logic lines_unused;
    assign lines_unused = ^lines_i[NUM_LINES-1:NUM_PINS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= pin_lvl_o;
  end

  assign pin_rise_o = pin_lvl_o & ~lvl_q;
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
  parameter int N  = 24,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irqd_eoi_fifo.sv
module irqd_eoi_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= data_i;
  end
endmodule

// File: rtl/irqd_engine.sv
module irqd_engine #(
  parameter int NUM_PINS  = 24,
  parameter int NUM_LINES = 32,
  parameter int EOI_DEPTH = 4,
  localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_LINES-1:0]     lines_i,
  input  logic [NUM_PINS*64-1:0]   rte_i,
  input  logic                     eoi_valid_i,
  input  logic [7:0]               eoi_vec_i,
  output logic                     msg_valid_o,
  input  logic                     msg_ready_i,
  output logic [31:0]              msg_addr_o,
  output logic [31:0]              msg_data_o,
  output logic [NUM_PINS-1:0]      rirr_o
);
  import irqd_pkg::*;

  ent_t                ent [NUM_PINS];
  logic [NUM_PINS-1:0] trig_v, mask_v, vec_hit;
  logic [NUM_PINS-1:0] pin_lvl, pin_rise;
  logic [NUM_PINS-1:0] irr_q, rirr_q, deliv;
  logic                pick_any, fire, idle, eoi_pop, load, fifo_empty;
  logic [IW-1:0]       pick_idx, held_q;
  logic [7:0]          eoi_head;
  logic                rte_unused;

  assign rte_unused = ^rte_i;  // reserved and read-only bits

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
    assign ent[p]     = ent_unpack(rte_i[p*ENT_W +: ENT_W]);
    assign trig_v[p]  = ent[p].trig;
    assign mask_v[p]  = ent[p].mask;
    assign vec_hit[p] = (ent[p].vec == eoi_head);
  end

  irqd_pin_front #(.NUM_PINS(NUM_PINS), .NUM_LINES(NUM_LINES)) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lines_i    (lines_i),
    .pin_lvl_o  (pin_lvl),
    .pin_rise_o (pin_rise)
  );

  irqd_eoi_fifo #(.DEPTH(EOI_DEPTH), .W(8)) u_eoi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (eoi_valid_i),
    .data_i  (eoi_vec_i),
    .pop_i   (eoi_pop),
    .data_o  (eoi_head),
    .empty_o (fifo_empty)
  );

  // level pins with remote-IRR set are not deliverable
  assign deliv = irr_q & ~mask_v & (~trig_v | ~rirr_q);

  irqd_pick #(.N(NUM_PINS)) u_pick (
    .req_i (deliv),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  assign idle    = !msg_valid_o;
  assign fire    = msg_valid_o && msg_ready_i;
  // queued EOIs take precedence over a new load so the next pick sees them
  assign eoi_pop = idle && !fifo_empty;
  assign load    = idle && fifo_empty && pick_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      rirr_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (trig_v[p]) begin
          irr_q[p] <= pin_lvl[p];
          if (eoi_pop && rirr_q[p] && vec_hit[p])      rirr_q[p] <= 1'b0;
          else if (fire && held_q == IW'(p))            rirr_q[p] <= 1'b1;
        end else begin
          rirr_q[p] <= 1'b0;
          if (pin_rise[p] && !mask_v[p])                irr_q[p] <= 1'b1;
          else if (fire && held_q == IW'(p))            irr_q[p] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
      held_q      <= '0;
    end else if (load) begin
      msg_valid_o <= 1'b1;
      msg_addr_o  <= msg_addr(ent[pick_idx]);
      msg_data_o  <= msg_data(ent[pick_idx]);
      held_q      <= pick_idx;
    end else if (fire) begin
      msg_valid_o <= 1'b0;
    end
  end

  assign rirr_o = rirr_q;
endmodule

// File: rtl/irqd_engine_chk.sv
module irqd_engine_chk #(
  parameter int NUM_PINS = 24
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_PINS*64-1:0] rte_i,
  input logic                   msg_valid_o,
  input logic                   msg_ready_i,
  input logic [31:0]            msg_addr_o,
  input logic [31:0]            msg_data_o,
  input logic [NUM_PINS-1:0]    rirr_o
);
  logic [NUM_PINS-1:0] trig_v;
  logic                chk_unused;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_t
    assign trig_v[p] = rte_i[p*64 + 15];
  end
  assign chk_unused = ^rte_i;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)); // R8

  AST_EDGE_CLEARS_RIRR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o || !msg_valid_o |=> (rirr_o & ~$past(trig_v)) == '0); // R11

  AST_RIRR_SET_ON_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rirr_o & ~$past(rirr_o))) |-> $past(msg_valid_o && msg_ready_i)); // R2

  AST_RIRR_ONE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rirr_o & ~$past(rirr_o)) <= 1); // R2

  AST_MSG_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_addr_o[31:20] == 12'hFEE && msg_addr_o[1:0] == 2'b00
                    && msg_data_o[31:16] == 16'h0); // R7
endmodule

bind irqd_engine irqd_engine_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/tb_irqd_engine.sv
module tb_irqd_engine;
  localparam int NP = 24;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic [63:0]   tbl [NP];
  logic [NP*64-1:0] rte;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vec = '0;
  logic          msg_valid, msg_ready = 1'b1;
  logic [31:0]   msg_addr, msg_data;
  logic [NP-1:0] rirr;
  logic          rnd_ready = 1'b0;
  logic [63:0]   got_q [$];
  int            n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  always_comb for (int p = 0; p < NP; p++) rte[p*64 +: 64] = tbl[p];

  irqd_engine #(.NUM_PINS(NP), .NUM_LINES(NL), .EOI_DEPTH(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .rte_i(rte),
    .eoi_valid_i(eoi_valid), .eoi_vec_i(eoi_vec),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data), .rirr_o(rirr)
  );

  always @(posedge clk) if (rst_n && msg_valid && msg_ready) got_q.push_back({msg_addr, msg_data});

  always @(negedge clk) if (rnd_ready) msg_ready <= ($urandom % 3) != 0;

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dlv, input logic dm,
                                     input logic lvl, input logic msk, input logic [15:0] dst);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dlv; e[11] = dm; e[15] = lvl; e[16] = msk; e[63:48] = dst;
    return e;
  endfunction

  function automatic logic [63:0] exp_msg(input logic [63:0] e);
    logic [31:0] a, d;
    a = 32'hFEE0_0000 | (32'(e[63:48]) << 4) | (32'(e[11]) << 2);
    d = 32'(e[7:0]) | (32'(e[10:8]) << 8) | (32'(e[15]) << 15);
    return {a, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic expect_msg(input string tag, input logic [63:0] e);
    logic [63:0] g;
    int t = 0;
    while (got_q.size() == 0 && t < 60) begin cyc(1); t++; end
    if (got_q.size() == 0) chk(1'b0, tag, 64'hdead, exp_msg(e));
    else begin g = got_q.pop_front(); chk(g == exp_msg(e), tag, g, exp_msg(e)); end
  endtask

  task automatic expect_none(input string tag, input int n);
    cyc(n);
    chk(got_q.size() == 0, tag, 64'(got_q.size()), 64'd0);
    got_q.delete();
  endtask

  task automatic pulse(input int ln);
    lines[ln] = 1'b1; cyc(2); lines[ln] = 1'b0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    eoi_vec = v; eoi_valid = 1'b1; cyc(1); eoi_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] a0;
    void'($urandom(32'd2024));
    for (int p = 0; p < NP; p++) tbl[p] = mk(8'h20 + 8'(p), 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1
    chk(msg_valid == 1'b0, "R1 valid after reset", 64'(msg_valid), 0);
    chk(rirr == '0, "R1 rirr after reset", 64'(rirr), 0);
    expect_none("R1 no message", 5);

    // R3: masked edge discarded, unmasked edge delivered once
    tbl[5] = mk(8'h51, 3'd1, 1'b0, 1'b0, 1'b1, 16'h0005);
    pulse(5); expect_none("R3 masked edge", 8);
    tbl[5][16] = 1'b0; expect_none("R3 unmask after discard", 10);
    tbl[6] = mk(8'h61, 3'd2, 1'b1, 1'b0, 1'b0, 16'hA5C3);
    pulse(6); expect_msg("R3 edge delivered", tbl[6]);
    expect_none("R3 request cleared", 10);

    // R2 + R9: level pin, remote-IRR handshake
    tbl[10] = mk(8'h31, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0102);
    lines[10] = 1'b1;
    expect_msg("R2 level delivered", tbl[10]);
    expect_none("R2 no repeat while remote set", 15);
    chk(rirr[10] == 1'b1, "R2 rirr set", 64'(rirr), 64'(1 << 10));
    send_eoi(8'h99); expect_none("R9 wrong vector", 10);
    chk(rirr[10] == 1'b1, "R9 wrong vector keeps rirr", 64'(rirr[10]), 1);
    send_eoi(8'h31); expect_msg("R9 redelivery", tbl[10]);
    lines[10] = 1'b0; cyc(2);
    send_eoi(8'h31); cyc(4);
    chk(rirr[10] == 1'b0, "R9 rirr cleared", 64'(rirr[10]), 0);
    expect_none("R2 line low no message", 10);

    // R5: masked level kept pending
    tbl[11] = mk(8'h41, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0011);
    lines[11] = 1'b1; expect_none("R5 masked level", 10);
    tbl[11][16] = 1'b0; expect_msg("R5 delivered on unmask", tbl[11]);
    lines[11] = 1'b0; cyc(2); send_eoi(8'h41); cyc(4);

    // R4: line routing
    tbl[2] = mk(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0002);
    tbl[0] = mk(8'h20, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000);
    pulse(0); expect_msg("R4 line0 to pin2", tbl[2]);
    expect_none("R4 no pin0 message", 10);
    pulse(28); expect_none("R4 line beyond pins", 10);
    tbl[0][16] = 1'b1;

    // R8 + R6: stall and ordering
    tbl[3] = mk(8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0003);
    tbl[7] = mk(8'h37, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0007);
    tbl[9] = mk(8'h39, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0009);
    msg_ready = 1'b0;
    lines[3] = 1'b1; lines[7] = 1'b1; lines[9] = 1'b1; cyc(2);
    lines[3] = 1'b0; lines[7] = 1'b0; lines[9] = 1'b0; cyc(4);
    chk(msg_valid == 1'b1, "R8 valid while stalled", 64'(msg_valid), 1);
    a0 = msg_addr;
    chk(a0 == exp_msg(tbl[3])[63:32], "R6 lowest pin first", 64'(a0), exp_msg(tbl[3]) >> 32);
    cyc(5);
    chk(msg_valid && msg_addr == a0, "R8 held stable", 64'(msg_addr), 64'(a0));
    msg_ready = 1'b1;
    expect_msg("R6 order pin3", tbl[3]);
    expect_msg("R6 order pin7", tbl[7]);
    expect_msg("R6 order pin9", tbl[9]);

    // R10: EOI during a held message
    tbl[12] = mk(8'h4C, 3'd0, 1'b0, 1'b1, 1'b0, 16'h000C);
    tbl[4]  = mk(8'h34, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0004);
    lines[12] = 1'b1; expect_msg("R10 level setup", tbl[12]);
    msg_ready = 1'b0; pulse(4); cyc(2);
    send_eoi(8'h4C); cyc(4);
    chk(rirr[12] == 1'b1, "R10 eoi deferred", 64'(rirr[12]), 1);
    msg_ready = 1'b1;
    expect_msg("R10 held message first", tbl[4]);
    expect_msg("R10 redelivery after", tbl[12]);

    // R11: level to edge clears remote-IRR
    lines[12] = 1'b0; cyc(2);
    chk(rirr[12] == 1'b1, "R11 rirr before rewrite", 64'(rirr[12]), 1);
    tbl[12][15] = 1'b0; cyc(2);
    chk(rirr[12] == 1'b0, "R11 rirr cleared", 64'(rirr[12]), 0);
    expect_none("R11 no spurious message", 8);

    // R7: random entries, random ready
    for (int p = 0; p < NP; p++) tbl[p][16] = 1'b1;
    rnd_ready = 1'b1;
    for (int k = 0; k < 24; k++) begin
      int pn = 1 + ($urandom % (NP - 1));
      tbl[pn] = mk(8'($urandom), 3'($urandom), 1'($urandom), 1'b0, 1'b0, 16'($urandom));
      pulse(pn);
      expect_msg("R7 random message fields", tbl[pn]);
      tbl[pn][16] = 1'b1;
    end
    rnd_ready = 1'b0; msg_ready = 1'b1;
    expect_none("R7 no extra messages", 10);
    finish_run();
  end
endmodule